// File: doc/BRIEF.md
# Dot Clock Timing Generator

This block produces every pixel-rate strobe of a video serializer from one dot clock. A free-running three-bit binary counter advances on each rising dot clock edge. Its top bit is the video clock that paces the display controller, one period per eight dots. One more bit toggles once per video clock period. That bit records whether the left or right byte of a 16-bit display word is currently being shifted out.

From the counter, the block decodes two strobes. The first is an active-low nibble-load strobe, once every four dots, which loads the final 4-bit shift registers. The second is an active-low sample enable, once per video clock period, which lets an external register resample blank and sync on one fixed dot. Every strobe is registered, so it appears one dot clock after its decode condition holds. The block also passes the serializer blank signal through one dot clock of delay, so that it lines up with the pixels leaving the shifters.

Top module: `dot_timing_gen`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next edge drives the 3-bit count to 0, byteSel to 0, loadN and sampleEnN to 1, and blankDly to 0.
- R2: Out of reset, the 3-bit count {vidClk, cntLow} increases by one on every rising edge and wraps from 7 to 0.
- R3: vidClk is bit 2 of the count: it is low for counts 0 to 3 and high for counts 4 to 7, giving one period per eight dot clocks.
- R4: byteSel inverts on the edge where the count wraps from 7 to 0 and holds on every other edge, so it has one period per sixteen dot clocks.
- R5: loadN is low for exactly the one cycle after a cycle in which cntLow equals 3. It is therefore low while cntLow equals 0, once every four dot clocks.
- R6: sampleEnN is low for exactly the one cycle after a cycle in which the full count equals 6. It is therefore low while the count equals 7, once per video clock period.
- R7: blankDly equals the value serBlankIn had at the previous rising edge.
- R8: A reset applied in the middle of a run returns all outputs to the R1 values on the next edge, and counting restarts from 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| serBlankIn | input | 1 | Serializer blank to be delayed |
| cntLow | output | 2 | Low two bits of the dot counter |
| vidClk | output | 1 | Video clock, counter bit 2 |
| byteSel | output | 1 | Byte tracker, divide-by-16 bit |
| loadN | output | 1 | Nibble-load strobe, active low |
| sampleEnN | output | 1 | Sync/blank sample enable, active low |
| blankDly | output | 1 | serBlankIn delayed one dot clock |

## Verification
The counter, vidClk and byteSel are due on the first edge after the state they are computed from. loadN and sampleEnN are due on the edge after their decode count, which is one register stage. blankDly is due on the edge after serBlankIn is presented. The bench drives inputs on the falling edge and pushes the outputs expected after the next rising edge, computed from its own copy of the count. A monitor pops each item 1 ns after that rising edge and compares it, so every comparison falls in exactly the cycle where the result is due.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  // decode requests from the control counter to the datapath registers
  typedef struct packed {
    logic loadHit;
    logic sampleHit;
  } strobeReq_t;
endpackage

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int LOAD_BITS   = 2,
  parameter int SAMPLE_CODE = 6
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count,
  output logic             byteSel,
  output strobeReq_t       req
);
  localparam logic [CNT_W-1:0] CNT_TOP   = '1;
  localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(SAMPLE_CODE);

  logic wrap;
  assign wrap = (count == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      byteSel <= 1'b0;
    end else begin
      count   <= count + 1'b1;
      byteSel <= byteSel ^ wrap;
    end
  end

  always_comb begin
    req           = '0;
    req.loadHit   = &count[LOAD_BITS-1:0];
    req.sampleHit = (count == SAMPLE_AT);
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> count == CNT_W'($past(count) + 1'b1));
  assert_byte_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_TOP) |=> byteSel != $past(byteSel));
  assert_byte_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (count != CNT_TOP) |=> $stable(byteSel));
endmodule

// File: rtl/dtg_dpath.sv
module dtg_dpath
  import dtg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  strobeReq_t req,
  input  logic       serBlankIn,
  output logic       loadN,
  output logic       sampleEnN,
  output logic       blankDly
);
  always_ff @(posedge clk) begin
    if (rst) begin
      loadN     <= 1'b1;
      sampleEnN <= 1'b1;
      blankDly  <= 1'b0;
    end else begin
      loadN     <= ~req.loadHit;
      sampleEnN <= ~req.sampleHit;
      blankDly  <= serBlankIn;
    end
  end

  assert_load_single_R5: assert property (@(posedge clk) disable iff (rst)
    !loadN |=> loadN);
  assert_load_follows_R5: assert property (@(posedge clk) disable iff (rst)
    req.loadHit |=> !loadN);
  assert_sample_single_R6: assert property (@(posedge clk) disable iff (rst)
    !sampleEnN |=> sampleEnN);
  assert_blank_delay_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> blankDly == $past(serBlankIn));
endmodule

// File: rtl/dot_timing_gen.sv
module dot_timing_gen
  import dtg_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int LOAD_BITS   = 2,
  parameter int SAMPLE_CODE = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 serBlankIn,
  output logic [LOAD_BITS-1:0] cntLow,
  output logic                 vidClk,
  output logic                 byteSel,
  output logic                 loadN,
  output logic                 sampleEnN,
  output logic                 blankDly
);
  logic [CNT_W-1:0] count;
  strobeReq_t       req;

  dtg_ctrl #(.CNT_W(CNT_W), .LOAD_BITS(LOAD_BITS), .SAMPLE_CODE(SAMPLE_CODE)) u_ctrl (
    .clk(clk), .rst(rst), .count(count), .byteSel(byteSel), .req(req)
  );

  dtg_dpath u_dpath (
    .clk(clk), .rst(rst), .req(req), .serBlankIn(serBlankIn),
    .loadN(loadN), .sampleEnN(sampleEnN), .blankDly(blankDly)
  );

  assign cntLow = count[LOAD_BITS-1:0];
  assign vidClk = count[CNT_W-1];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == '0) && !byteSel && loadN && sampleEnN && !blankDly);
endmodule

// File: tb/dot_timing_gen_bench.sv
`timescale 1ns/1ps
module dot_timing_gen_bench;
  typedef struct packed {
    logic [2:0] cnt;
    logic       bsel;
    logic       ld;
    logic       smp;
    logic       blk;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serBlankIn = 1'b0;
  logic [1:0] cntLow;
  logic vidClk, byteSel, loadN, sampleEnN, blankDly;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  expItem_t expQ[$];
  expItem_t model = '{cnt: 3'd0, bsel: 1'b0, ld: 1'b1, smp: 1'b1, blk: 1'b0};

  always #2 clk = ~clk;

  dot_timing_gen u_dot_timing_gen (
    .clk(clk), .rst(rst), .serBlankIn(serBlankIn), .cntLow(cntLow),
    .vidClk(vidClk), .byteSel(byteSel), .loadN(loadN),
    .sampleEnN(sampleEnN), .blankDly(blankDly)
  );

  task automatic step(input logic r, input logic b);
    expItem_t nxt;
    @(negedge clk);
    rst = r;
    serBlankIn = b;
    if (r) begin
      nxt = '{cnt: 3'd0, bsel: 1'b0, ld: 1'b1, smp: 1'b1, blk: 1'b0};
    end else begin
      nxt.cnt  = model.cnt + 3'd1;
      nxt.bsel = model.bsel ^ (model.cnt == 3'd7);
      nxt.ld   = (model.cnt[1:0] == 2'd3) ? 1'b0 : 1'b1;
      nxt.smp  = (model.cnt == 3'd6) ? 1'b0 : 1'b1;
      nxt.blk  = b;
    end
    model = nxt;
    expQ.push_back(nxt);
  endtask

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compares each due item just after the edge that produces it
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        if (e.cnt == 3'd0 && e.bsel == 1'b0 && e.ld && e.smp && !e.blk && rst)
          check("R1/R8 reset", {vidClk, cntLow, byteSel}, {3'd0, 1'b0} >> 1);
        check("R2 count", {vidClk, cntLow}, e.cnt);
        check("R3 vidClk", {2'b00, vidClk}, {2'b00, e.cnt[2]});
        check("R4 byteSel", {2'b00, byteSel}, {2'b00, e.bsel});
        check("R5 loadN", {2'b00, loadN}, {2'b00, e.ld});
        check("R6 sampleEnN", {2'b00, sampleEnN}, {2'b00, e.smp});
        check("R7 blankDly", {2'b00, blankDly}, {2'b00, e.blk});
      end
    end
  end

  // driver: reset, long run with varied blank, mid-run reset, second run
  initial begin
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 45; i++) step(1'b0, (i % 5 == 2) || (i % 7 == 0));
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    for (int i = 0; i < 35; i++) step(1'b0, i[0]);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule